// File: doc/BRIEF.md
# Gap-Framed Serial Memory Command Engine

This block sits behind a byte-wide serial receiver and transmitter and acts as a command slave. A host sends binary packets. The block finds where each packet ends by watching for silence on the line. It checks a CRC-16 over the whole packet and then carries out the packet's read and write commands on eight memory spaces. Each space also has a small read-only info area that describes it. Read data goes back to the host as one reply packet with its own CRC.

Each command begins with two bytes.

- The first byte holds the element count and a flag that turns on address increment.
- The second byte chooses read or write, says whether an address follows, chooses the info area or the data, picks the space and sets the element size.

Addresses count 16-bit words. A 32-bit element takes two consecutive words. One address pointer carries over from command to command and from packet to packet.

A packet is executed only after its CRC has been checked, so a corrupted packet leaves no trace. Some spaces are protected. A write to one of them takes effect only while a guard register holds a key that names that space. The guard register clears itself when each packet ends.

Top module: `spe_engine`

## Requirements
- R1: A packet ends after GAP_BITS*CLKS_PER_BIT consecutive clock cycles with no rx_valid. The next received byte is the first byte of a new packet. A pause of fewer idle cycles keeps the bytes in the same packet.
- R2: A packet is executed only if all three of these hold:
  - it has between 2 and PKT_MAX bytes;
  - the last two bytes are the CRC, low byte first;
  - running the CRC-16 (polynomial 0x1021, reflected form 0x8408, initial value 0, no final XOR) over every byte of the packet leaves 0.
  Any other packet is discarded: no write takes effect and no reply is sent.
- R3: The first byte of a command is the count/increment byte. Bit 7 turns on address increment, and bits 6:0 give the number of elements. A count of 0 moves no data but still loads any address that follows.
- R4: The second byte of a command is the command byte:
  - bit 7: 1 = write, 0 = read;
  - bit 6: 1 = a 16-bit address follows;
  - bit 5: 1 = info area, 0 = memory data;
  - bits 4:2: space number;
  - bits 1:0: size code 10 means a 32-bit element; every other code means a 16-bit element.
- R5: When an address is present, it arrives low byte first and replaces the pointer. When no address is present, the command uses the pointer left by the previous command, even if that command was in an earlier packet. The pointer is 0 after reset.
- R6: Addresses are 16-bit word indices, reduced modulo 2^AW inside the selected space. A 32-bit element occupies words p (low half) and p+1 (high half). With increment on, the pointer advances by 1 after each 16-bit element and by 2 after each 32-bit element. With increment off it stays put.
- R7: Write data follows the address, low byte first within each word and low word first within a 32-bit element.
- R8: The reply contains only the read data bytes, in request order and in the same byte order as writes, followed by the CRC of those bytes, low byte first. A packet with no reads produces no reply.
- R9: The info area of space s is read-only. Its 16-bit word offsets hold:
  - 0: 0x5A00+s;
  - 1: 2^AW;
  - 2: {ERASE_LOG2[4:0], PAGE_LOG2[4:0], AW+1 as 6 bits};
  - 3: the current pointer;
  - 4: 0x5053;
  - 5: 0x0030+s;
  - all other offsets: 0.
  Writes to the info area are ignored. A 32-bit read of the info area returns zero data.
- R10: Word 0 of space CTRL_SPACE is the write-enable guard register, and it can be read and written. A write to a space whose PROT_MASK bit is set takes effect only while the guard holds 0x5A00 plus that space's number. The guard is cleared at the end of every executed packet.
- R11: Bytes that arrive while a packet is executing are ignored and do not become part of any later packet.
- R12: After reset, tx_valid is low, the pointer is 0 and the guard is 0.
- R13: tx_valid stays high with tx_data unchanged until a cycle in which tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_valid | output | 1 | A reply byte is offered |
| tx_data | output | 8 | Reply byte |

## Verification
The assertions check four things on every cycle:
- the transmit hold rule;
- that reply bytes appear only while a packet executes;
- that a write to a protected space happens only under the matching key, and that the key is gone once a packet finishes;
- that bytes arriving during execution never change the receive buffer, and that execution never starts on fewer than two bytes.

Only the bench's scenarios can show the rest:
- correct data, byte order and pointer movement;
- that a corrupted, overlong or split packet leaves memory untouched;
- the contents of the info area.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [4:0] {
    X_IDLE, X_FETCH, X_CNT, X_CMD, X_ALO, X_AHI, X_ELEM, X_WLO, X_WHI,
    X_RREQ, X_RWAIT, X_TXHI, X_RNEXT, X_SEND, X_END, X_CRC1, X_DONE
  } xstate_t;

  localparam logic [15:0] KEY_BASE = 16'h5A00;

  // one byte of the reflected CRC-16 (poly 0x1021, reflected 0x8408), LSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/spe_framer.sv
module spe_framer #(
  parameter int PKT_MAX  = 64,
  parameter int GAP_CLKS = 128,
  parameter int LW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          busy,
  input  logic [LW-1:0] rd_ptr,
  output logic [7:0]    rd_byte,
  output logic          start,
  output logic [LW-1:0] data_len
);
  import spe_pkg::*;
  localparam int IW = $clog2(PKT_MAX);
  localparam int GW = $clog2(GAP_CLKS + 1);

  logic [7:0]    pbuf [PKT_MAX];
  logic [LW-1:0] wptr;
  logic [15:0]   crc;
  logic [GW-1:0] gcnt;
  logic          active, ovf, take, room;

  assign take = rx_valid && !busy;
  assign room = (wptr < LW'(PKT_MAX));

  // packet buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (take && room) pbuf[wptr[IW-1:0]] <= rx_data;
    rd_byte <= pbuf[rd_ptr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; crc <= '0; gcnt <= '0; active <= 1'b0; ovf <= 1'b0;
      start <= 1'b0; data_len <= '0;
    end else begin
      start <= 1'b0;
      if (take) begin
        if (room) wptr <= wptr + 1'b1;
        else      ovf  <= 1'b1;
        crc    <= crc16_step(crc, rx_data);
        active <= 1'b1;
        gcnt   <= '0;
      end else if (active) begin
        if (gcnt == GW'(GAP_CLKS - 1)) begin
          active   <= 1'b0;
          start    <= (crc == 16'h0000) && (wptr >= LW'(2)) && !ovf;
          data_len <= wptr - LW'(2);
          wptr     <= '0;
          crc      <= '0;
          ovf      <= 1'b0;
          gcnt     <= '0;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
      end
    end
  end

  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid) |=> $stable(wptr));
  assert_start_len_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> ($past(wptr) >= LW'(2)));
endmodule

// File: rtl/spe_mem.sv
module spe_mem #(
  parameter int MW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [MW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [1 << MW];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/spe_info.sv
module spe_info #(
  parameter int AW         = 6,
  parameter int ERASE_LOG2 = 6,
  parameter int PAGE_LOG2  = 4
) (
  input  logic [2:0]  space,
  input  logic [15:0] offset,
  input  logic [15:0] ptr,
  output logic [15:0] word
);
  always_comb begin
    case (offset)
      16'd0:   word = 16'h5A00 | {13'd0, space};
      16'd1:   word = 16'(1 << AW);
      16'd2:   word = {5'(ERASE_LOG2), 5'(PAGE_LOG2), 6'(AW + 1)};
      16'd3:   word = ptr;
      16'd4:   word = 16'h5053;
      16'd5:   word = 16'h0030 | {13'd0, space};
      default: word = 16'h0000;
    endcase
  end
endmodule

// File: rtl/spe_engine.sv
module spe_engine #(
  parameter int          CLKS_PER_BIT = 8,
  parameter int          GAP_BITS     = 16,
  parameter int          PKT_MAX      = 64,
  parameter int          AW           = 6,
  parameter logic [7:0]  PROT_MASK    = 8'h06,
  parameter int          CTRL_SPACE   = 7,
  parameter int          ERASE_LOG2   = 6,
  parameter int          PAGE_LOG2    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  import spe_pkg::*;
  localparam int GAP_CLKS = CLKS_PER_BIT * GAP_BITS;
  localparam int LW       = $clog2(PKT_MAX + 1);
  localparam int MW       = AW + 3;

  xstate_t       st, ret;
  logic [LW-1:0] rptr, dlen;
  logic [7:0]    rbyte, wlo, sb;
  logic          start, busy;
  logic          inc, wr, info, sz32, widx, replied;
  logic [6:0]    cnt;
  logic [2:0]    sp;
  logic [15:0]   ptr, wa, txw, crc_tx, crcf, wren, info_word, mem_rdata;
  logic          ctrl0, key_ok, mem_we;
  logic [MW-1:0] midx;

  assign busy   = (st != X_IDLE) || start;
  assign wa     = ptr + {15'd0, widx};
  assign midx   = {sp, wa[AW-1:0]};
  assign ctrl0  = (sp == 3'(CTRL_SPACE)) && (wa[AW-1:0] == '0);
  assign key_ok = !PROT_MASK[sp] || (wren == (KEY_BASE | {13'd0, sp}));
  assign mem_we = (st == X_WHI) && !info && !ctrl0 && key_ok;

  spe_framer #(.PKT_MAX(PKT_MAX), .GAP_CLKS(GAP_CLKS), .LW(LW)) u_framer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .rd_ptr(rptr), .rd_byte(rbyte), .start(start), .data_len(dlen));

  spe_mem #(.MW(MW), .DW(16)) u_mem (
    .clk(clk), .we(mem_we), .addr(midx), .wdata({rbyte, wlo}), .rdata(mem_rdata));

  spe_info #(.AW(AW), .ERASE_LOG2(ERASE_LOG2), .PAGE_LOG2(PAGE_LOG2)) u_info (
    .space(sp), .offset(wa), .ptr(ptr), .word(info_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= X_IDLE; ret <= X_IDLE; rptr <= '0; inc <= 1'b0; wr <= 1'b0; info <= 1'b0;
      sz32 <= 1'b0; widx <= 1'b0; replied <= 1'b0; cnt <= '0; sp <= '0; ptr <= '0;
      wlo <= '0; sb <= '0; txw <= '0; crc_tx <= '0; crcf <= '0; wren <= '0;
      tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      case (st)
        X_IDLE: if (start) begin
          rptr <= '0; crc_tx <= '0; replied <= 1'b0; st <= X_FETCH; ret <= X_CNT;
        end
        X_FETCH: if (rptr >= dlen) st <= X_END;
                 else begin rptr <= rptr + 1'b1; st <= ret; end
        X_CNT: begin inc <= rbyte[7]; cnt <= rbyte[6:0]; st <= X_FETCH; ret <= X_CMD; end
        X_CMD: begin
          wr <= rbyte[7]; info <= rbyte[5]; sp <= rbyte[4:2]; sz32 <= (rbyte[1:0] == 2'b10);
          if (rbyte[6]) begin st <= X_FETCH; ret <= X_ALO; end
          else st <= X_ELEM;
        end
        X_ALO: begin ptr[7:0] <= rbyte; st <= X_FETCH; ret <= X_AHI; end
        X_AHI: begin ptr[15:8] <= rbyte; st <= X_ELEM; end
        X_ELEM: if (cnt == '0) begin st <= X_FETCH; ret <= X_CNT; end
                else begin
                  widx <= 1'b0;
                  if (wr) begin st <= X_FETCH; ret <= X_WLO; end
                  else st <= X_RREQ;
                end
        X_WLO: begin wlo <= rbyte; st <= X_FETCH; ret <= X_WHI; end
        X_WHI: begin
          if (!info && ctrl0) wren <= {rbyte, wlo};
          if (widx == sz32) begin
            if (inc) ptr <= ptr + (sz32 ? 16'd2 : 16'd1);
            cnt <= cnt - 1'b1; st <= X_ELEM;
          end else begin widx <= 1'b1; st <= X_FETCH; ret <= X_WLO; end
        end
        X_RREQ: st <= X_RWAIT;
        X_RWAIT: begin
          txw <= info ? (sz32 ? 16'h0000 : info_word) : (ctrl0 ? wren : mem_rdata);
          sb  <= info ? (sz32 ? 8'h00 : info_word[7:0]) : (ctrl0 ? wren[7:0] : mem_rdata[7:0]);
          replied <= 1'b1; st <= X_SEND; ret <= X_TXHI;
        end
        X_TXHI: begin sb <= txw[15:8]; st <= X_SEND; ret <= X_RNEXT; end
        X_RNEXT: if (widx == sz32) begin
                   if (inc) ptr <= ptr + (sz32 ? 16'd2 : 16'd1);
                   cnt <= cnt - 1'b1; st <= X_ELEM;
                 end else begin widx <= 1'b1; st <= X_RREQ; end
        X_SEND: if (!tx_valid) begin
                  tx_valid <= 1'b1; tx_data <= sb; crc_tx <= crc16_step(crc_tx, sb);
                end else if (tx_ready) begin
                  tx_valid <= 1'b0; st <= ret;
                end
        X_END: if (replied) begin
                 crcf <= crc_tx; sb <= crc_tx[7:0]; st <= X_SEND; ret <= X_CRC1;
               end else st <= X_DONE;
        X_CRC1: begin sb <= crcf[15:8]; st <= X_SEND; ret <= X_DONE; end
        X_DONE: begin wren <= '0; st <= X_IDLE; end
        default: st <= X_IDLE;
      endcase
    end
  end

  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_tx_in_exec_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (st == X_SEND));
  assert_guard_key_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_we && PROT_MASK[sp]) |-> (wren == (KEY_BASE | {13'd0, sp})));
  assert_guard_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (st == X_IDLE && $past(st) != X_IDLE) |-> (wren == 16'h0000));
endmodule

// File: tb/sim_spe_engine.sv
module sim_spe_engine;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_CLKS   = 8 * 16;
  localparam logic [7:0] PROT = 8'h06;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 1'b0, tx_ready = 1'b0, tx_valid;
  logic [7:0] rx_data = '0, tx_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  pkt [0:127];
  int          pn;
  logic [7:0]  expd [0:255];
  int          en;
  logic [7:0]  got [0:255];
  int          gn = 0;
  logic [15:0] mmem [0:511];
  logic [15:0] mptr = '0, mwren = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spe_engine u0 (.clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
                 .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data));

  // back-pressure and reply capture, away from the active edge
  always @(negedge clk) begin
    tx_ready = rst ? 1'b0 : (($urandom % 4) != 0);
    if (tx_valid && tx_ready) begin got[gn] = tx_data; gn = gn + 1; end
  end

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic add(input logic [7:0] b); pkt[pn] = b; pn++; endtask

  task automatic seal();
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < pn; i++) c = bcrc(c, pkt[i]);
    add(c[7:0]); add(c[15:8]);
  endtask

  function automatic logic [15:0] minfo(input int s, input logic [15:0] off);
    case (off)
      16'd0: return 16'h5A00 + 16'(s);
      16'd1: return 16'd64;
      16'd2: return {5'd6, 5'd4, 6'd7};
      16'd3: return mptr;
      16'd4: return 16'h5053;
      16'd5: return 16'h0030 + 16'(s);
      default: return 16'h0000;
    endcase
  endfunction

  // expected effect and reply of a well-formed packet, from the requirements
  task automatic model_run();
    int dl, i, idx, s;
    logic [7:0] nb, cb;
    logic [15:0] a, d, c;
    bit ctl, big;
    dl = pn - 2; i = 0; en = 0; c = 16'h0000;
    while (i < dl) begin
      nb = pkt[i]; i++;
      if (i >= dl) break;
      cb = pkt[i]; i++;
      if (cb[6]) begin mptr = {pkt[i+1], pkt[i]}; i += 2; end
      s = int'(cb[4:2]); big = (cb[1:0] == 2'b10);
      for (int k = 0; k < int'(nb[6:0]); k++) begin
        for (int w = 0; w <= int'(big); w++) begin
          a = mptr + 16'(w); idx = s * 64 + int'(a[5:0]);
          ctl = (s == 7) && (a[5:0] == 6'd0);
          if (cb[7]) begin
            d = {pkt[i+1], pkt[i]}; i += 2;
            if (!cb[5]) begin
              if (ctl) mwren = d;
              else if (!(PROT[s] && mwren != 16'h5A00 + 16'(s))) mmem[idx] = d;
            end
          end else begin
            d = cb[5] ? (big ? 16'h0000 : minfo(s, a)) : (ctl ? mwren : mmem[idx]);
            expd[en] = d[7:0];  c = bcrc(c, d[7:0]);  en++;
            expd[en] = d[15:8]; c = bcrc(c, d[15:8]); en++;
          end
        end
        if (nb[7]) mptr = mptr + (big ? 16'd2 : 16'd1);
      end
    end
    if (en > 0) begin expd[en] = c[7:0]; en++; expd[en] = c[15:8]; en++; end
    mwren = 16'h0000;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (GAP_CLKS + 6 * pn + 12 * en + 80) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    check({tag, " reply length"}, gn, en);
    for (int i = 0; i < en && i < gn; i++) check({tag, " reply byte"}, got[i], expd[i]);
  endtask

  task automatic xfer(input string tag, input bit good);
    if (good) model_run(); else en = 0;
    gn = 0;
    for (int i = 0; i < pn; i++) send_byte(pkt[i]);
    settle();
    compare(tag);
  endtask

  task automatic rand_cmd(input bit allow_info);
    logic [7:0] nb, cb;
    int cntv, words;
    cntv = $urandom % 4;
    nb = {1'($urandom % 2), 7'(cntv)};
    cb = {1'($urandom % 2), 1'(($urandom % 4) != 0), 1'(allow_info && ($urandom % 5) == 0),
          3'($urandom % 8), 2'($urandom % 4)};
    add(nb); add(cb);
    if (cb[6]) begin
      add(8'($urandom % 64)); add((($urandom % 8) == 0) ? 8'h01 : 8'h00);
    end
    words = cntv * ((cb[1:0] == 2'b10) ? 2 : 1);
    if (cb[7]) for (int j = 0; j < words; j++) begin add(8'($urandom)); add(8'($urandom)); end
  endtask

  task automatic add_key(input int s);
    add(8'h01); add(8'hDD); add(8'h00); add(8'h00); add(8'(s)); add(8'h5A);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 tx_valid after reset", tx_valid, 0);

    // R12 R9: address-less info read at the reset pointer gives the cookie of space 0
    pn = 0; add(8'h01); add(8'h21); seal(); xfer("R12 R9 cookie at pointer 0", 1);

    // fill every space (R10 key for protected ones)
    for (int s = 0; s < 8; s++)
      for (int ch = 0; ch < 4; ch++) begin
        pn = 0;
        if (PROT[s]) add_key(s);
        add(8'h90); add(8'hC1 | 8'(s << 2)); add(8'(ch * 16)); add(8'h00);
        for (int w = 0; w < 16; w++) begin
          add(8'(s * 37 + ch * 16 + w)); add(8'(8'hC0 ^ 8'(s * 16 + w)));
        end
        seal(); xfer("R10 R7 fill", 1);
      end

    // R9: info area of space 3, six words with increment
    pn = 0; add(8'h86); add(8'h6D); add(8'h00); add(8'h00); seal(); xfer("R9 info words", 1);
    // R9: write to info ignored, 32-bit info read is zero
    pn = 0; add(8'h01); add(8'hE9); add(8'h00); add(8'h00); add(8'h12); add(8'h34);
    add(8'h01); add(8'h69); add(8'h00); add(8'h00);
    add(8'h01); add(8'h6A); add(8'h00); add(8'h00); seal(); xfer("R9 info write ignored", 1);

    // R6 R7: 32-bit write with increment, read back as 16-bit words, and 32-bit read
    pn = 0; add(8'h82); add(8'hC2); add(8'd20); add(8'h00);
    for (int j = 1; j <= 8; j++) add(8'(j * 17));
    add(8'h84); add(8'h41); add(8'd20); add(8'h00);
    add(8'h02); add(8'h42); add(8'd20); add(8'h00); seal(); xfer("R6 R7 32-bit order", 1);
    // R6: increment off repeats the address; address wraps modulo the space
    pn = 0; add(8'h03); add(8'hC1); add(8'd30); add(8'h00);
    add(8'h0A); add(8'h0B); add(8'h0C); add(8'h0D); add(8'h0E); add(8'h0F);
    add(8'h81); add(8'h41); add(8'd30); add(8'h00);
    add(8'h81); add(8'h41); add(8'h41); add(8'h00); seal(); xfer("R6 no-inc and wrap", 1);

    // R3 R5: zero count loads the address; pointer persists into the next packet
    pn = 0; add(8'h00); add(8'h41); add(8'd40); add(8'h00); add(8'h82); add(8'h01);
    seal(); xfer("R3 zero count", 1);
    pn = 0; add(8'h81); add(8'h01); seal(); xfer("R5 pointer persists", 1);

    // R8: write-only packet has no reply
    pn = 0; add(8'h01); add(8'hC1); add(8'd45); add(8'h00); add(8'h77); add(8'h66);
    seal(); xfer("R8 no reads no reply", 1);

    // R10: protected write without key ignored; key from an earlier packet is gone
    pn = 0; add_key(1); seal(); xfer("R10 key alone", 1);
    pn = 0; add(8'h01); add(8'hC5); add(8'd5); add(8'h00); add(8'hEE); add(8'hDD);
    add(8'h01); add(8'h45); add(8'd5); add(8'h00); seal(); xfer("R10 key cleared", 1);
    pn = 0; add_key(2); add(8'h01); add(8'hC9); add(8'd6); add(8'h00); add(8'h55); add(8'hAA);
    add(8'h01); add(8'h49); add(8'd6); add(8'h00);
    add(8'h01); add(8'h5D); add(8'h00); add(8'h00); seal(); xfer("R10 keyed write", 1);

    // R2: corrupted CRC, short packet, overlong packet all dropped
    pn = 0; add(8'h01); add(8'hC1); add(8'd50); add(8'h00); add(8'h99); add(8'h88);
    add(8'h01); add(8'h41); add(8'd50); add(8'h00); seal(); pkt[4] ^= 8'h10;
    xfer("R2 bad crc dropped", 0);
    pn = 0; add(8'h01); xfer("R2 short dropped", 0);
    pn = 0; add(8'h01); add(8'hC1); add(8'd50); add(8'h00); add(8'h31); add(8'h32);
    while (pn < 66) begin add(8'h00); add(8'h01); end
    add(8'h01); add(8'h41); add(8'd50); add(8'h00); seal(); xfer("R2 overlong dropped", 0);
    pn = 0; add(8'h01); add(8'h41); add(8'd50); add(8'h00); seal(); xfer("R2 memory untouched", 1);

    // R1: a pause past the gap splits a packet; a pause just under it does not
    pn = 0; add(8'h01); add(8'hC1); add(8'd51); add(8'h00); add(8'h44); add(8'h33); seal();
    en = 0; gn = 0;
    for (int i = 0; i < 4; i++) send_byte(pkt[i]);
    repeat (GAP_CLKS + 10) @(negedge clk);
    for (int i = 4; i < pn; i++) send_byte(pkt[i]);
    settle(); compare("R1 split by gap");
    model_run(); gn = 0;
    for (int i = 0; i < 4; i++) send_byte(pkt[i]);
    repeat (GAP_CLKS - 12) @(negedge clk);
    for (int i = 4; i < pn; i++) send_byte(pkt[i]);
    settle(); compare("R1 pause under gap");
    pn = 0; add(8'h01); add(8'h41); add(8'd51); add(8'h00); seal(); xfer("R1 readback", 1);

    // R11: stray byte during execution is not kept
    pn = 0; add(8'h83); add(8'h42); add(8'h00); add(8'h00); seal();
    model_run(); gn = 0;
    for (int i = 0; i < pn; i++) send_byte(pkt[i]);
    repeat (GAP_CLKS + 3) @(negedge clk);
    send_byte(8'hA7);
    settle(); compare("R11 reply during stray byte");
    pn = 0; add(8'h01); add(8'h41); add(8'd2); add(8'h00); seal(); xfer("R11 next packet clean", 1);

    // R4 R8 R13: random packets under random back-pressure, some corrupted
    for (int t = 0; t < 40; t++) begin
      int ncmd;
      bit bad;
      pn = 0;
      if ($urandom % 2) add_key($urandom % 8);
      ncmd = 1 + ($urandom % 3);
      for (int c = 0; c < ncmd; c++) rand_cmd(1);
      seal();
      bad = (($urandom % 10) == 0);
      if (bad) pkt[$urandom % pn] ^= 8'(1 << ($urandom % 8));
      xfer(bad ? "R2 random corrupted" : "R4 R8 R13 random", !bad);
    end

    // full readback of every space
    for (int s = 0; s < 8; s++)
      for (int ch = 0; ch < 4; ch++) begin
        pn = 0; add(8'h90); add(8'h41 | 8'(s << 2)); add(8'(ch * 16)); add(8'h00);
        seal(); xfer("R10 R2 final readback", 1);
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule